// File: doc/BRIEF.md
# Square-Wave Duty Sequencer

This block produces the one-bit waveform of a square-wave sound channel. An external period timer pulses `tick_i` once per period. Each pulse moves an eight-position step counter one place downward, and the counter wraps from position 0 back to position 7. A two-bit duty selector picks one of four high/low patterns. The output level is the pattern bit at the counter's current position.

When software writes the channel's upper period register, `period_hi_wr_i` pulses. That pulse returns the step counter to position 0, so every note starts at a known phase. The patterns are laid out for a counter that counts down. A fresh note therefore holds its starting level at position 0, and its high portion begins on the first tick, when the counter wraps to 7.

Top module: `pulse_duty_seq`

## Requirements
- R1: While rst_ni is low, the step counter is held at 0 and level_o is 0 for every value of duty_mode_i. After reset is released, the first tick moves the counter to position 7.
- R2: On a clock edge with tick_i high and period_hi_wr_i low, the step counter goes down by one.
- R3: A tick taken while the counter is at position 0 moves it to position 7.
- R4: On a clock edge with period_hi_wr_i high, the counter becomes 0, whether or not tick_i is also high.
- R5: On a clock edge with tick_i and period_hi_wr_i both low, the counter keeps its position.
- R6: When duty_mode_i = 0, level_o is 1 only at position 7 (1 of 8 steps high).
- R7: When duty_mode_i = 1, level_o is 1 only at positions 7 and 6 (2 of 8).
- R8: When duty_mode_i = 2, level_o is 1 only at positions 7, 6, 5 and 4 (4 of 8).
- R9: When duty_mode_i = 3, level_o is the inverse of the mode 1 pattern: it is 1 at positions 5 down to 0.
- R10: level_o follows duty_mode_i and the counter position combinationally, with no register in between, so a change of mode shows on level_o in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Period timer pulse; moves the counter one step |
| period_hi_wr_i | input | 1 | Pulse marking a write to the upper period register; restarts the phase |
| duty_mode_i | input | 2 | Duty pattern select (0: 12.5%, 1: 25%, 2: 50%, 3: inverted 25%) |
| level_o | output | 1 | Waveform level |

## Verification
On every cycle, the assertions check how the counter moves: a decrement by one, the wrap from 0 to 7, restart taking priority over a tick, and holding when no pulse arrives. They also check that the output is low during reset, and that level_o for modes 0 and 3 agrees with the counter position. The bench scenarios cover what the assertions do not. They walk the counter through more than two full wraps, and at each position they sweep all four modes with no clock edge in between. This shows each whole pattern, the rule that mode 3 is the inverse of mode 1, and the same-cycle response to a mode change. Only the scenarios show the phase a note takes after a restart, including a restart that arrives in the same cycle as a tick.

// File: rtl/pulse_duty_pkg.sv
package pulse_duty_pkg;

  typedef enum logic [1:0] {
    DUTY_EIGHTH    = 2'd0,
    DUTY_QUARTER   = 2'd1,
    DUTY_HALF      = 2'd2,
    DUTY_QUARTER_N = 2'd3
  } duty_mode_e;

  // Number of high steps in a period of `steps` for the non-inverted modes.
  function automatic int unsigned high_steps(input int unsigned mode, input int unsigned steps);
    case (mode)
      0:       return steps / 8;
      1:       return steps / 4;
      default: return steps / 2;
    endcase
  endfunction

  // Pattern bit at position `pos`. High positions sit at the top, because
  // the counter reaches the top first after a restart to 0.
  function automatic logic pattern_bit(input int unsigned mode, input int unsigned pos,
                                       input int unsigned steps);
    logic hi;
    if (mode == 3) begin
      hi = (pos >= steps - high_steps(1, steps));
      return ~hi;
    end
    return (pos >= steps - high_steps(mode, steps));
  endfunction

endpackage

// File: rtl/pulse_duty_counter.sv
module pulse_duty_counter #(
  parameter int unsigned STEPS = 8,
  localparam int unsigned CW = $clog2(STEPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  output logic [CW-1:0] pos_o
);

  logic [CW-1:0] pos_q, pos_d;

  // A restart outranks a tick in the same cycle.
  always_comb begin
    pos_d = pos_q;
    if (restart_i)   pos_d = '0;
    else if (tick_i) pos_d = pos_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign pos_o = pos_q;

endmodule

// File: rtl/pulse_duty_table.sv
module pulse_duty_table
  import pulse_duty_pkg::*;
#(
  parameter int unsigned STEPS = 8,
  localparam int unsigned CW = $clog2(STEPS),
  localparam int unsigned NMODES = 4
) (
  input  duty_mode_e    mode_i,
  input  logic [CW-1:0] pos_i,
  output logic          level_o
);

  logic [NMODES-1:0][STEPS-1:0] rows;

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    for (genvar p = 0; p < STEPS; p++) begin : g_pos
      assign rows[m][p] = pattern_bit(m, p, STEPS);
    end
  end

  assign level_o = rows[mode_i][pos_i];

endmodule

// File: rtl/pulse_duty_seq.sv
module pulse_duty_seq
  import pulse_duty_pkg::*;
#(
  parameter int unsigned STEPS = 8,
  localparam int unsigned CW = $clog2(STEPS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       period_hi_wr_i,
  input  logic [1:0] duty_mode_i,
  output logic       level_o
);

  logic [CW-1:0] pos;
  duty_mode_e    mode_eff;

  // Force mode 0 while in reset so the output stays low.
  assign mode_eff = rst_ni ? duty_mode_e'(duty_mode_i) : DUTY_EIGHTH;

  pulse_duty_counter #(.STEPS(STEPS)) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .restart_i (period_hi_wr_i),
    .pos_o     (pos)
  );

  pulse_duty_table #(.STEPS(STEPS)) i_table (
    .mode_i  (mode_eff),
    .pos_i   (pos),
    .level_o (level_o)
  );

endmodule

// File: rtl/pulse_duty_seq_chk.sv
module pulse_duty_seq_chk #(
  parameter int unsigned STEPS = 8,
  localparam int unsigned CW = $clog2(STEPS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          period_hi_wr_i,
  input logic [1:0]    duty_mode_i,
  input logic          level_o,
  input logic [CW-1:0] pos
);

  localparam logic [CW-1:0] TOP = CW'(STEPS - 1);

  p_reset_low_r1: assert property (@(posedge clk_i) !rst_ni |-> !level_o);

  p_step_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !period_hi_wr_i && pos != '0) |=> pos == $past(pos) - 1'b1);

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !period_hi_wr_i && pos == '0) |=> pos == TOP);

  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_hi_wr_i |=> pos == '0);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !period_hi_wr_i) |=> $stable(pos));

  p_eighth_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_mode_i == 2'd0 && level_o) |-> pos == TOP);

  p_inverse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_mode_i == 2'd3 && pos == '0) |-> level_o);

endmodule

bind pulse_duty_seq pulse_duty_seq_chk #(.STEPS(STEPS)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tick_i         (tick_i),
  .period_hi_wr_i (period_hi_wr_i),
  .duty_mode_i    (duty_mode_i),
  .level_o        (level_o),
  .pos            (pos)
);

// File: tb/test_pulse_duty_seq.sv
`timescale 1ns/1ps
module test_pulse_duty_seq;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       period_hi_wr_i = 1'b0;
  logic [1:0] duty_mode_i = 2'd0;
  logic       level_o;

  int checks = 0;
  int errors = 0;
  int model_pos = 0;

  always #5 clk_i = ~clk_i;

  pulse_duty_seq i_pulse_duty_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (tick_i),
    .period_hi_wr_i (period_hi_wr_i),
    .duty_mode_i    (duty_mode_i),
    .level_o        (level_o)
  );

  function automatic logic expect_level(input int m, input int p);
    case (m)
      0: return p >= 7;
      1: return p >= 6;
      2: return p >= 4;
      default: return !(p >= 6);
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos=%0d mode=%0d actual=%b expected=%b", req, model_pos, duty_mode_i, act, exp);
    end
  endtask

  // Sweep every mode with no clock edge between: R6..R9 patterns, R10 same-cycle response.
  task automatic sweep(input string tag);
    for (int m = 0; m < 4; m++) begin
      duty_mode_i = 2'(m);
      #0.5;
      case (m)
        0: check({tag, " R6 R10"}, level_o, expect_level(m, model_pos));
        1: check({tag, " R7 R10"}, level_o, expect_level(m, model_pos));
        2: check({tag, " R8 R10"}, level_o, expect_level(m, model_pos));
        default: check({tag, " R9 R10"}, level_o, expect_level(m, model_pos));
      endcase
    end
  endtask

  task automatic cycle(input logic t, input logic w, input string tag);
    @(negedge clk_i);
    tick_i = t;
    period_hi_wr_i = w;
    @(posedge clk_i);
    #1;
    tick_i = 1'b0;
    period_hi_wr_i = 1'b0;
    if (w) model_pos = 0;
    else if (t) model_pos = (model_pos + 7) % 8;
    sweep(tag);
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: output low in reset, for every mode.
    #2;
    for (int m = 0; m < 4; m++) begin
      duty_mode_i = 2'(m);
      #0.5;
      check("R1 reset", level_o, 1'b0);
    end
    repeat (2) @(posedge clk_i);
    tick_i = 1'b1;
    @(posedge clk_i);
    #1;
    check("R1 tick ignored in reset", level_o, 1'b0);
    tick_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_pos = 0;
    sweep("R1 after reset");

    // R2, R3: walk through more than two wraps.
    for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0, (model_pos == 0) ? "R3 wrap" : "R2 step");

    // R5: idle cycles hold the position.
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, "R5 hold");

    // R4: restart alone, after moving away from 0.
    cycle(1'b1, 1'b0, "R2 step");
    cycle(1'b1, 1'b0, "R2 step");
    cycle(1'b0, 1'b1, "R4 restart");
    cycle(1'b1, 1'b0, "R3 wrap after restart");

    // R4: restart together with a tick wins.
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, "R2 step");
    cycle(1'b1, 1'b1, "R4 restart with tick");
    cycle(1'b0, 1'b0, "R5 hold");
    for (int i = 0; i < 9; i++) cycle(1'b1, 1'b0, "R2 R3 after restart");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule